// File: doc/BRIEF.md
# Pipeline Hazard Controller

This block decides, for a five-stage in-order pipeline with 32 architectural registers, where each operand should come from and when the front of the pipeline must wait. The pipeline stages are fetch, decode, execute, memory and writeback. Branches are resolved early, in decode, so the block covers two hazard paths. The usual path gives each execute operand a bypass select and raises a stall when a load result is needed by the next instruction. The early-branch path gives each decode comparator operand a bypass select and raises a stall when a branch needs a value that is not ready yet.

The decisions themselves are purely combinational. The outputs pass through one output register that is cleared by a synchronous active-high reset. The pipeline loads its fetch and decode registers with the inverse of the hold outputs. When the execute clear output is high, the pipeline zeroes its execute register so that the stage behaves as a no-operation.

Top module: `hz_ctrl_unit`

## Requirements
- R1: All outputs are registered: each output shows, one clock after the inputs were sampled, the decision for those inputs. A clock with `rst` high clears every output to 0.
- R2: The execute select for operand A is 2'b10 (bypass from the memory stage) when `ex_rs` is nonzero, equals `mem_dst`, and `mem_wr` is 1. This check overrides the writeback check.
- R3: When R2 does not apply, the operand A select is 2'b01 (bypass from writeback) if `ex_rs` is nonzero, equals `wb_dst`, and `wb_wr` is 1. Otherwise the select is 2'b00 (register file value).
- R4: The operand B select follows the rules of R2 and R3, with `ex_rt` taking the place of `ex_rs`.
- R5: A source number of 0 never produces a bypass on either execute select or either branch select, whatever the destination numbers and write bits are.
- R6: Branch bypass bit A (or B) is 1 exactly when `dec_rs` (or `dec_rt`) is nonzero, equals `mem_dst`, and `mem_wr` is 1.
- R7: A load-use stall occurs when `ex_ld` is 1 and either `dec_rs` or `dec_rt` equals `ex_rt`.
- R8: A branch stall occurs when `dec_branch` and `ex_wr` are both 1 and `ex_dst` equals `dec_rs` or `dec_rt`.
- R9: A branch stall also occurs when `dec_branch` and `mem_ld` are both 1 and `mem_dst` equals `dec_rs` or `dec_rt`.
- R10: `hold_fetch`, `hold_dec` and `clear_ex` are always equal. Each is the OR of the load-use stall and the branch stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dec_rs | input | 5 | First source register in decode |
| dec_rt | input | 5 | Second source register in decode |
| dec_branch | input | 1 | A branch is in decode |
| ex_rs | input | 5 | First source register in execute |
| ex_rt | input | 5 | Second source register in execute |
| ex_dst | input | 5 | Destination register in execute |
| ex_wr | input | 1 | Execute instruction writes a register |
| ex_ld | input | 1 | Execute instruction is a load |
| mem_dst | input | 5 | Destination register in memory stage |
| mem_wr | input | 1 | Memory-stage instruction writes a register |
| mem_ld | input | 1 | Memory-stage instruction is a load |
| wb_dst | input | 5 | Destination register in writeback |
| wb_wr | input | 1 | Writeback instruction writes a register |
| ex_sel_a | output | 2 | Operand A source select for execute |
| ex_sel_b | output | 2 | Operand B source select for execute |
| br_fwd_a | output | 1 | Bypass memory result to branch operand A |
| br_fwd_b | output | 1 | Bypass memory result to branch operand B |
| hold_fetch | output | 1 | Fetch stall (the PC enable is its inverse) |
| hold_dec | output | 1 | Decode stall (the decode enable is its inverse) |
| clear_ex | output | 1 | Clear the execute register to zero |

## Verification
Each decision is available exactly one clock after the inputs it depends on. The bench changes its inputs on a falling edge and computes the expected outputs for that input set at the same moment. It compares them on the next falling edge, after the output register has captured the set and before any new inputs are applied. The register numbers are drawn from a small range so that matches, priority collisions and register 0 occur often. Directed cases pin down the priority between the memory and writeback bypasses, the zero register, and each stall source alone.

// File: rtl/hz_pkg.sv
package hz_pkg;
  typedef enum logic [1:0] {
    SEL_RF  = 2'b00,
    SEL_WB  = 2'b01,
    SEL_MEM = 2'b10
  } fwd_sel_e;
endpackage

// File: rtl/hz_exec_fwd.sv
module hz_exec_fwd #(
  parameter int REG_COUNT = 32,
  localparam int AW = $clog2(REG_COUNT)
) (
  input  logic [AW-1:0]    src,
  input  logic [AW-1:0]    mem_dst,
  input  logic             mem_wr,
  input  logic [AW-1:0]    wb_dst,
  input  logic             wb_wr,
  output hz_pkg::fwd_sel_e sel
);
  logic live;
  logic mem_hit;
  logic wb_hit;

  assign live    = (src != '0);
  assign mem_hit = live && mem_wr && (src == mem_dst);
  assign wb_hit  = live && wb_wr && (src == wb_dst);

  // The younger producer in memory wins over the older one in writeback.
  always_comb begin
    if (mem_hit)     sel = hz_pkg::SEL_MEM;
    else if (wb_hit) sel = hz_pkg::SEL_WB;
    else             sel = hz_pkg::SEL_RF;
  end
endmodule

// File: rtl/hz_branch_fwd.sv
module hz_branch_fwd #(
  parameter int REG_COUNT = 32,
  localparam int AW = $clog2(REG_COUNT)
) (
  input  logic [AW-1:0] src,
  input  logic [AW-1:0] mem_dst,
  input  logic          mem_wr,
  output logic          hit
);
  assign hit = (src != '0) && mem_wr && (src == mem_dst);
endmodule

// File: rtl/hz_stall_detect.sv
module hz_stall_detect #(
  parameter int REG_COUNT = 32,
  localparam int AW = $clog2(REG_COUNT)
) (
  input  logic [AW-1:0] dec_rs,
  input  logic [AW-1:0] dec_rt,
  input  logic          dec_branch,
  input  logic [AW-1:0] ex_rt,
  input  logic [AW-1:0] ex_dst,
  input  logic          ex_wr,
  input  logic          ex_ld,
  input  logic [AW-1:0] mem_dst,
  input  logic          mem_ld,
  output logic          load_use,
  output logic          br_stall
);
  logic ld_match;
  logic ex_match;
  logic mem_match;

  // A load in execute targets its rt field.
  assign ld_match  = (dec_rs == ex_rt) || (dec_rt == ex_rt);
  assign ex_match  = (dec_rs == ex_dst) || (dec_rt == ex_dst);
  assign mem_match = (dec_rs == mem_dst) || (dec_rt == mem_dst);

  assign load_use = ex_ld && ld_match;
  assign br_stall = dec_branch && ((ex_wr && ex_match) || (mem_ld && mem_match));
endmodule

// File: rtl/hz_ctrl_unit.sv
module hz_ctrl_unit #(
  parameter int REG_COUNT = 32,
  localparam int AW = $clog2(REG_COUNT),
  localparam int NOPS = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] dec_rs,
  input  logic [AW-1:0] dec_rt,
  input  logic          dec_branch,
  input  logic [AW-1:0] ex_rs,
  input  logic [AW-1:0] ex_rt,
  input  logic [AW-1:0] ex_dst,
  input  logic          ex_wr,
  input  logic          ex_ld,
  input  logic [AW-1:0] mem_dst,
  input  logic          mem_wr,
  input  logic          mem_ld,
  input  logic [AW-1:0] wb_dst,
  input  logic          wb_wr,
  output logic [1:0]    ex_sel_a,
  output logic [1:0]    ex_sel_b,
  output logic          br_fwd_a,
  output logic          br_fwd_b,
  output logic          hold_fetch,
  output logic          hold_dec,
  output logic          clear_ex
);
  logic [AW-1:0]    ex_src  [NOPS];
  logic [AW-1:0]    dec_src [NOPS];
  hz_pkg::fwd_sel_e ex_sel  [NOPS];
  logic             br_hit  [NOPS];
  logic             load_use;
  logic             br_stall;
  logic             hold_any;

  assign ex_src[0]  = ex_rs;
  assign ex_src[1]  = ex_rt;
  assign dec_src[0] = dec_rs;
  assign dec_src[1] = dec_rt;

  for (genvar g = 0; g < NOPS; g++) begin : g_opnd
    hz_exec_fwd #(.REG_COUNT(REG_COUNT)) u_exf (
      .src     (ex_src[g]),
      .mem_dst (mem_dst),
      .mem_wr  (mem_wr),
      .wb_dst  (wb_dst),
      .wb_wr   (wb_wr),
      .sel     (ex_sel[g])
    );
    hz_branch_fwd #(.REG_COUNT(REG_COUNT)) u_brf (
      .src     (dec_src[g]),
      .mem_dst (mem_dst),
      .mem_wr  (mem_wr),
      .hit     (br_hit[g])
    );
  end

  hz_stall_detect #(.REG_COUNT(REG_COUNT)) u_stall (
    .dec_rs     (dec_rs),
    .dec_rt     (dec_rt),
    .dec_branch (dec_branch),
    .ex_rt      (ex_rt),
    .ex_dst     (ex_dst),
    .ex_wr      (ex_wr),
    .ex_ld      (ex_ld),
    .mem_dst    (mem_dst),
    .mem_ld     (mem_ld),
    .load_use   (load_use),
    .br_stall   (br_stall)
  );

  assign hold_any = load_use || br_stall;

  always_ff @(posedge clk) begin
    if (rst) begin
      ex_sel_a   <= 2'b00;
      ex_sel_b   <= 2'b00;
      br_fwd_a   <= 1'b0;
      br_fwd_b   <= 1'b0;
      hold_fetch <= 1'b0;
      hold_dec   <= 1'b0;
      clear_ex   <= 1'b0;
    end else begin
      ex_sel_a   <= ex_sel[0];
      ex_sel_b   <= ex_sel[1];
      br_fwd_a   <= br_hit[0];
      br_fwd_b   <= br_hit[1];
      hold_fetch <= hold_any;
      hold_dec   <= hold_any;
      clear_ex   <= hold_any;
    end
  end
endmodule

// File: rtl/hz_ctrl_chk.sv
module hz_ctrl_chk #(
  parameter int REG_COUNT = 32,
  localparam int AW = $clog2(REG_COUNT)
) (
  input logic          clk,
  input logic          rst,
  input logic [AW-1:0] dec_rs,
  input logic [AW-1:0] dec_rt,
  input logic          dec_branch,
  input logic [AW-1:0] ex_rs,
  input logic [AW-1:0] ex_rt,
  input logic [AW-1:0] ex_dst,
  input logic          ex_wr,
  input logic          ex_ld,
  input logic [AW-1:0] mem_dst,
  input logic          mem_wr,
  input logic          mem_ld,
  input logic [AW-1:0] wb_dst,
  input logic          wb_wr,
  input logic [1:0]    ex_sel_a,
  input logic [1:0]    ex_sel_b,
  input logic          br_fwd_a,
  input logic          br_fwd_b,
  input logic          hold_fetch,
  input logic          hold_dec,
  input logic          clear_ex
);
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (ex_sel_a == 2'b00 && ex_sel_b == 2'b00 && !br_fwd_a && !br_fwd_b
             && !hold_fetch && !hold_dec && !clear_ex));

  // R2
  mem_first_a_chk: assert property (@(posedge clk) disable iff (rst)
    (ex_rs != '0 && mem_wr && ex_rs == mem_dst) |=> ex_sel_a == 2'b10);

  // R3
  wb_second_a_chk: assert property (@(posedge clk) disable iff (rst)
    (ex_rs != '0 && !(mem_wr && ex_rs == mem_dst) && wb_wr && ex_rs == wb_dst)
      |=> ex_sel_a == 2'b01);

  // R4
  mem_first_b_chk: assert property (@(posedge clk) disable iff (rst)
    (ex_rt != '0 && mem_wr && ex_rt == mem_dst) |=> ex_sel_b == 2'b10);

  // R5
  zero_reg_chk: assert property (@(posedge clk) disable iff (rst)
    (ex_rs == '0 && dec_rt == '0) |=> (ex_sel_a == 2'b00 && !br_fwd_b));

  // R6
  branch_fwd_chk: assert property (@(posedge clk) disable iff (rst)
    (dec_rs != '0 && mem_wr && dec_rs == mem_dst) |=> br_fwd_a);

  // R7
  load_use_chk: assert property (@(posedge clk) disable iff (rst)
    (ex_ld && (dec_rs == ex_rt || dec_rt == ex_rt)) |=> hold_fetch);

  // R8
  br_ex_chk: assert property (@(posedge clk) disable iff (rst)
    (dec_branch && ex_wr && (dec_rs == ex_dst || dec_rt == ex_dst)) |=> hold_dec);

  // R9
  br_mem_chk: assert property (@(posedge clk) disable iff (rst)
    (dec_branch && mem_ld && (dec_rs == mem_dst || dec_rt == mem_dst)) |=> clear_ex);

  // R10
  holds_equal_chk: assert property (@(posedge clk) disable iff (rst)
    (hold_fetch == hold_dec) && (hold_dec == clear_ex));
endmodule

bind hz_ctrl_unit hz_ctrl_chk #(.REG_COUNT(REG_COUNT)) u_chk (
  .clk(clk), .rst(rst), .dec_rs(dec_rs), .dec_rt(dec_rt), .dec_branch(dec_branch),
  .ex_rs(ex_rs), .ex_rt(ex_rt), .ex_dst(ex_dst), .ex_wr(ex_wr), .ex_ld(ex_ld),
  .mem_dst(mem_dst), .mem_wr(mem_wr), .mem_ld(mem_ld), .wb_dst(wb_dst), .wb_wr(wb_wr),
  .ex_sel_a(ex_sel_a), .ex_sel_b(ex_sel_b), .br_fwd_a(br_fwd_a), .br_fwd_b(br_fwd_b),
  .hold_fetch(hold_fetch), .hold_dec(hold_dec), .clear_ex(clear_ex)
);

// File: tb/hz_ctrl_unit_tb.sv
module hz_ctrl_unit_tb;
  logic       clk = 1'b0;
  logic       rst;
  logic [4:0] dec_rs, dec_rt, ex_rs, ex_rt, ex_dst, mem_dst, wb_dst;
  logic       dec_branch, ex_wr, ex_ld, mem_wr, mem_ld, wb_wr;
  logic [1:0] ex_sel_a, ex_sel_b;
  logic       br_fwd_a, br_fwd_b, hold_fetch, hold_dec, clear_ex;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #10 clk = ~clk;

  hz_ctrl_unit u_dut (
    .clk(clk), .rst(rst), .dec_rs(dec_rs), .dec_rt(dec_rt), .dec_branch(dec_branch),
    .ex_rs(ex_rs), .ex_rt(ex_rt), .ex_dst(ex_dst), .ex_wr(ex_wr), .ex_ld(ex_ld),
    .mem_dst(mem_dst), .mem_wr(mem_wr), .mem_ld(mem_ld), .wb_dst(wb_dst), .wb_wr(wb_wr),
    .ex_sel_a(ex_sel_a), .ex_sel_b(ex_sel_b), .br_fwd_a(br_fwd_a), .br_fwd_b(br_fwd_b),
    .hold_fetch(hold_fetch), .hold_dec(hold_dec), .clear_ex(clear_ex)
  );

  // Reference decisions written from the requirements.
  function automatic logic [1:0] ref_sel(input logic [4:0] s);
    if (s != 0 && mem_wr && s == mem_dst) return 2'b10;
    if (s != 0 && wb_wr && s == wb_dst)   return 2'b01;
    return 2'b00;
  endfunction

  function automatic logic ref_br(input logic [4:0] s);
    return (s != 0) && mem_wr && (s == mem_dst);
  endfunction

  function automatic logic ref_lu();
    return ex_ld && (dec_rs == ex_rt || dec_rt == ex_rt);
  endfunction

  function automatic logic ref_bs_ex();
    return dec_branch && ex_wr && (dec_rs == ex_dst || dec_rt == ex_dst);
  endfunction

  function automatic logic ref_bs_mem();
    return dec_branch && mem_ld && (dec_rs == mem_dst || dec_rt == mem_dst);
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Expected values, captured when the inputs are applied.
  logic [1:0] e_sa, e_sb;
  logic       e_ba, e_bb, e_hold;
  string      t_sa, t_sb, t_ba, t_bb, t_hold;

  function automatic string sel_tag(input logic [4:0] s, input string def);
    if (s == 0) return "R5";
    if (mem_wr && s == mem_dst) return def;
    return "R3";
  endfunction

  task automatic apply(input logic [4:0] drs, drt, input logic dbr,
                       input logic [4:0] ers, ert, edst, input logic ewr, eld,
                       input logic [4:0] mdst, input logic mwr, mld,
                       input logic [4:0] wdst, input logic wwr);
    dec_rs = drs; dec_rt = drt; dec_branch = dbr;
    ex_rs = ers; ex_rt = ert; ex_dst = edst; ex_wr = ewr; ex_ld = eld;
    mem_dst = mdst; mem_wr = mwr; mem_ld = mld; wb_dst = wdst; wb_wr = wwr;
    e_sa = ref_sel(ex_rs);
    e_sb = ref_sel(ex_rt);
    e_ba = ref_br(dec_rs);
    e_bb = ref_br(dec_rt);
    e_hold = ref_lu() || ref_bs_ex() || ref_bs_mem();
    t_sa = sel_tag(ex_rs, "R2");
    t_sb = (ex_rt == 0) ? "R5" : "R4";
    t_ba = (dec_rs == 0) ? "R5" : "R6";
    t_bb = (dec_rt == 0) ? "R5" : "R6";
    if (ref_lu())          t_hold = "R7";
    else if (ref_bs_ex())  t_hold = "R8";
    else if (ref_bs_mem()) t_hold = "R9";
    else                   t_hold = "R10";
  endtask

  // Called one falling edge after apply: one register stage lies between.
  task automatic verify();
    check(t_sa, int'(ex_sel_a), int'(e_sa));
    check(t_sb, int'(ex_sel_b), int'(e_sb));
    check(t_ba, int'(br_fwd_a), int'(e_ba));
    check(t_bb, int'(br_fwd_b), int'(e_bb));
    check(t_hold, int'(hold_fetch), int'(e_hold));
    check("R10", int'(hold_dec), int'(e_hold));
    check("R10", int'(clear_ex), int'(e_hold));
  endtask

  task automatic step();
    @(negedge clk);
    verify();
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : stim
    void'($urandom(32'd1234));
    rst = 1'b1;
    apply(5'd3, 5'd3, 1'b1, 5'd3, 5'd3, 5'd3, 1'b1, 1'b1, 5'd3, 1'b1, 1'b1, 5'd3, 1'b1);
    repeat (3) @(negedge clk);
    // R1: reset clears every output even with hazard-rich inputs
    check("R1", int'(ex_sel_a), 0);
    check("R1", int'(ex_sel_b), 0);
    check("R1", int'(hold_fetch), 0);
    check("R1", int'(br_fwd_a), 0);
    rst = 1'b0;

    // R2: memory bypass beats writeback on the same register
    apply(5'd0, 5'd0, 1'b0, 5'd7, 5'd1, 5'd0, 1'b0, 1'b0, 5'd7, 1'b1, 1'b0, 5'd7, 1'b1);
    step();
    // R3: writeback bypass when the memory stage does not write
    apply(5'd0, 5'd0, 1'b0, 5'd7, 5'd9, 5'd0, 1'b0, 1'b0, 5'd7, 1'b0, 1'b0, 5'd7, 1'b1);
    step();
    // R4: operand B bypass from memory, A from writeback
    apply(5'd0, 5'd0, 1'b0, 5'd4, 5'd9, 5'd0, 1'b0, 1'b0, 5'd9, 1'b1, 1'b0, 5'd4, 1'b1);
    step();
    // R5: register 0 matched everywhere yet never bypassed
    apply(5'd0, 5'd0, 1'b0, 5'd0, 5'd0, 5'd0, 1'b0, 1'b0, 5'd0, 1'b1, 1'b0, 5'd0, 1'b1);
    step();
    // R6: branch operand bypass on rt only
    apply(5'd2, 5'd12, 1'b0, 5'd0, 5'd0, 5'd0, 1'b0, 1'b0, 5'd12, 1'b1, 1'b0, 5'd0, 1'b0);
    step();
    // R7: load-use on decode rt
    apply(5'd1, 5'd6, 1'b0, 5'd0, 5'd6, 5'd6, 1'b1, 1'b1, 5'd0, 1'b0, 1'b0, 5'd0, 1'b0);
    step();
    // R8: branch waits on an execute-stage write
    apply(5'd8, 5'd1, 1'b1, 5'd0, 5'd2, 5'd8, 1'b1, 1'b0, 5'd0, 1'b0, 1'b0, 5'd0, 1'b0);
    step();
    // R8: same match without a branch does not stall
    apply(5'd8, 5'd1, 1'b0, 5'd0, 5'd2, 5'd8, 1'b1, 1'b0, 5'd0, 1'b0, 1'b0, 5'd0, 1'b0);
    step();
    // R9: branch waits on a load in memory
    apply(5'd3, 5'd11, 1'b1, 5'd0, 5'd2, 5'd0, 1'b0, 1'b0, 5'd11, 1'b1, 1'b1, 5'd0, 1'b0);
    step();

    // Random mix with a narrow register range so matches are frequent.
    for (int i = 0; i < 3000; i++) begin
      apply(5'($urandom_range(0, 3)), 5'($urandom_range(0, 3)), 1'($urandom),
            5'($urandom_range(0, 3)), 5'($urandom_range(0, 3)), 5'($urandom_range(0, 3)),
            1'($urandom), 1'($urandom),
            5'($urandom_range(0, 3)), 1'($urandom), 1'($urandom),
            5'($urandom_range(0, 3)), 1'($urandom));
      step();
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule